// File: doc/BRIEF.md
# Indexed Gather/Scatter Address Generator

This block runs a one-dimensional indexed copy between word locations of a data memory. A job is configured on the input pins and launched with a one-cycle `start` pulse. For every element position, the block reads one or two unsigned index words from a separate index memory. It turns each index into a word address as `base + index * step`. It then reads one source word and writes one destination word. A leg that is not indexed walks linearly as `base + position * step`.

The addressing mode selects which legs are indexed: only the source (gather), only the destination (scatter), or both. When both legs are indexed, each leg has its own index vector. Each indexed leg has its own upper bound. An out-of-range index either halts the job and reports the failing position (hard policy) or skips that element (soft policy). Selecting the add operation together with the duplicates-allowed flag turns each write into a read-modify-write. Repeated destination indices then accumulate. An illegal configuration is refused before any memory traffic starts.

Top module: `idx_xfer_engine`

## Requirements
- R1: With mode field `cfg_flags[1:0]` = 0 (gather), element i reads the index word at `src_ix_base + i`, reads data from `src_base + idx * src_step` and writes it to `dst_base + i * dst_step`.
- R2: With mode 1 (scatter), element i reads the index word at `dst_ix_base + i`, reads data from `src_base + i * src_step` and writes it to `dst_base + idx * dst_step`. Destination words that no index selects keep their value.
- R3: With mode 2 (both), the source index comes from `src_ix_base + i` and the destination index comes from `dst_ix_base + i`. Each leg uses its own base and step.
- R4: A start is refused when any of these holds: mode is 3; `cfg_flags[5:4]` (gather dim) is nonzero; `cfg_flags[7:6]` (scatter dim) is nonzero; `cfg_rsvd` is nonzero; `cfg_chan` is not 128. A refused start sets `rejected` to 1, pulses `done` and issues no index or data request.
- R5: A count of 4096 is accepted and runs all elements. A count of 4097 or more is refused as in R4.
- R6: An index is out of range only when it is strictly greater than the leg's bound (`src_bound` or `dst_bound`). An index equal to the bound is transferred normally.
- R7: With `cfg_flags[2]` = 1, an out-of-range index sets `oob_err` and loads `err_pos` with the element position. No further write is issued. Earlier elements stay written.
- R8: With `cfg_flags[2]` = 0, an element with an out-of-range index is skipped without a write, and later elements proceed. `oob_err` stays 0.
- R9: When `cfg_op` = 1 (add) and `cfg_flags[3]` = 1, each write stores the old destination word plus the source word, so repeated destinations accumulate. Any other combination stores the source word unchanged.
- R10: Elements are processed in ascending position order, one memory request at a time. In copy mode, a later duplicate destination overwrites an earlier one.
- R11: After reset, `busy`, `done`, `rejected`, `oob_err`, `mem_req`, `mem_we` and `ix_req` are 0.
- R12: A valid job with count 0 pulses `done` without any request.
- R13: `done` is high for exactly one cycle per start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a job while idle |
| cfg_flags | input | 8 | Mode [1:0], hard bound [2], duplicates allowed [3], gather dim [5:4], scatter dim [7:6] |
| cfg_op | input | 3 | Write operation: 1 = add, others = copy |
| cfg_chan | input | 8 | Index channel count, must be 128 |
| cfg_rsvd | input | 16 | Must be zero |
| cfg_count | input | 16 | Number of elements |
| src_base | input | ADDR_W | Source base word address |
| src_step | input | ADDR_W | Source step in words |
| dst_base | input | ADDR_W | Destination base word address |
| dst_step | input | ADDR_W | Destination step in words |
| src_bound | input | IDX_W | Largest legal source index |
| dst_bound | input | IDX_W | Largest legal destination index |
| src_ix_base | input | IX_AW | Index memory address of the source index vector |
| dst_ix_base | input | IX_AW | Index memory address of the destination index vector |
| ix_req | output | 1 | Index memory read request |
| ix_addr | output | IX_AW | Index memory address |
| ix_rdata | input | IDX_W | Index word, valid one cycle after the request |
| mem_req | output | 1 | Data memory request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | ADDR_W | Data memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read request |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | Last start was refused |
| oob_err | output | 1 | Last job halted on an out-of-range index |
| err_pos | output | 13 | Element position of the halting index |

## Verification
The three modes are driven with index vectors that mix repeated and scattered values. This separates a source-side index from a destination-side index, and separates an indexed leg from a linear leg. Duplicate destinations are run twice: once with add plus the duplicates flag, where an accumulated sum results, and once in copy mode, where the last write wins. Index values at, just above and far above a bound separate strict and inclusive comparison and show hard halting versus soft skipping on both legs. Each refusal condition and the counts 0, 4096 and 4097 are checked against the total number of memory requests issued.

// File: rtl/idxdma_pkg.sv
package idxdma_pkg;

  localparam logic [1:0] MODE_GATHER  = 2'd0;
  localparam logic [1:0] MODE_SCATTER = 2'd1;
  localparam logic [1:0] MODE_BOTH    = 2'd2;
  localparam logic [2:0] OP_ADD       = 3'd1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IXRD,
    ST_IXGOT,
    ST_SRD,
    ST_SGOT,
    ST_DRD,
    ST_DGOT,
    ST_WR,
    ST_WAIT,
    ST_NEXT,
    ST_FIN
  } xfer_st_t;

endpackage

// File: rtl/cfg_check.sv
module cfg_check #(
  parameter int MAX_CNT  = 4096,
  parameter int CHANNELS = 128,
  parameter int CNT_IN_W = 16
) (
  input  logic [7:0]          flags,
  input  logic [7:0]          chan,
  input  logic [15:0]         rsvd,
  input  logic [CNT_IN_W-1:0] count,
  output logic                ok
);
  logic mode_ok, dims_ok, misc_ok, cnt_ok;

  assign mode_ok = (flags[1:0] != 2'd3);
  // only the X dimension exists here, so both dim fields must be zero
  assign dims_ok = (flags[7:4] == 4'd0);
  assign misc_ok = (rsvd == 16'd0) && (chan == 8'(CHANNELS));
  assign cnt_ok  = (count <= CNT_IN_W'(MAX_CNT));
  assign ok      = mode_ok && dims_ok && misc_ok && cnt_ok;
endmodule

// File: rtl/leg_addr.sv
module leg_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 32,
  parameter int CNT_W  = 13
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] step,
  input  logic              use_idx,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CNT_W-1:0]  pos,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] off;

  assign off  = use_idx ? ADDR_W'(idx) : ADDR_W'(pos);
  assign addr = base + off * step;
endmodule

// File: rtl/idx_xfer_engine.sv
module idx_xfer_engine
  import idxdma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 32,
  parameter int IX_AW    = 16,
  parameter int CNT_IN_W = 16,
  parameter int MAX_CNT  = 4096,
  parameter int CHANNELS = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [7:0]          cfg_flags,
  input  logic [2:0]          cfg_op,
  input  logic [7:0]          cfg_chan,
  input  logic [15:0]         cfg_rsvd,
  input  logic [CNT_IN_W-1:0] cfg_count,
  input  logic [ADDR_W-1:0]   src_base,
  input  logic [ADDR_W-1:0]   src_step,
  input  logic [ADDR_W-1:0]   dst_base,
  input  logic [ADDR_W-1:0]   dst_step,
  input  logic [IDX_W-1:0]    src_bound,
  input  logic [IDX_W-1:0]    dst_bound,
  input  logic [IX_AW-1:0]    src_ix_base,
  input  logic [IX_AW-1:0]    dst_ix_base,
  output logic                ix_req,
  output logic [IX_AW-1:0]    ix_addr,
  input  logic [IDX_W-1:0]    ix_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic                rejected,
  output logic                oob_err,
  output logic [12:0]         err_pos
);
  localparam int CNT_W = $clog2(MAX_CNT + 1);
  localparam int NLEG  = 2;

  xfer_st_t st, ret_st;
  logic             cfg_ok;
  logic [1:0]       mode_q;
  logic             hard_q, acc_q, leg_sel;
  logic [CNT_W-1:0] pos, cnt_q;
  logic [DATA_W-1:0] sdat, ddat;

  logic [ADDR_W-1:0] leg_base  [NLEG];
  logic [ADDR_W-1:0] leg_step  [NLEG];
  logic [IDX_W-1:0]  leg_bound [NLEG];
  logic [IX_AW-1:0]  leg_ixb   [NLEG];
  logic [IDX_W-1:0]  leg_idx   [NLEG];
  logic              leg_ix    [NLEG];
  logic [ADDR_W-1:0] leg_ea    [NLEG];

  cfg_check #(.MAX_CNT(MAX_CNT), .CHANNELS(CHANNELS), .CNT_IN_W(CNT_IN_W)) u_chk (
    .flags(cfg_flags), .chan(cfg_chan), .rsvd(cfg_rsvd), .count(cfg_count), .ok(cfg_ok)
  );

  // leg 0 = source, leg 1 = destination
  assign leg_ix[0] = (mode_q != MODE_SCATTER);
  assign leg_ix[1] = (mode_q != MODE_GATHER);

  generate
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
      leg_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_addr (
        .base(leg_base[g]), .step(leg_step[g]), .use_idx(leg_ix[g]),
        .idx(leg_idx[g]), .pos(pos), .addr(leg_ea[g])
      );
    end
  endgenerate

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ret_st    <= ST_IDLE;
      mode_q    <= MODE_GATHER;
      hard_q    <= 1'b0;
      acc_q     <= 1'b0;
      leg_sel   <= 1'b0;
      pos       <= '0;
      cnt_q     <= '0;
      sdat      <= '0;
      ddat      <= '0;
      ix_req    <= 1'b0;
      ix_addr   <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      rejected  <= 1'b0;
      oob_err   <= 1'b0;
      err_pos   <= '0;
      for (int k = 0; k < NLEG; k++) begin
        leg_base[k]  <= '0;
        leg_step[k]  <= '0;
        leg_bound[k] <= '0;
        leg_ixb[k]   <= '0;
        leg_idx[k]   <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          mode_q       <= cfg_flags[1:0];
          hard_q       <= cfg_flags[2];
          acc_q        <= cfg_flags[3] && (cfg_op == OP_ADD);
          leg_base[0]  <= src_base;
          leg_base[1]  <= dst_base;
          leg_step[0]  <= src_step;
          leg_step[1]  <= dst_step;
          leg_bound[0] <= src_bound;
          leg_bound[1] <= dst_bound;
          leg_ixb[0]   <= src_ix_base;
          leg_ixb[1]   <= dst_ix_base;
          cnt_q        <= cfg_count[CNT_W-1:0];
          pos          <= '0;
          rejected     <= !cfg_ok;
          oob_err      <= 1'b0;
          err_pos      <= '0;
          leg_sel      <= (cfg_flags[1:0] == MODE_SCATTER);
          st           <= (!cfg_ok || cfg_count == '0) ? ST_FIN : ST_IXRD;
        end
        ST_IXRD: begin
          ix_req  <= 1'b1;
          ix_addr <= leg_ixb[leg_sel] + IX_AW'(pos);
          ret_st  <= ST_IXGOT;
          st      <= ST_WAIT;
        end
        ST_WAIT: begin
          ix_req  <= 1'b0;
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          st      <= ret_st;
        end
        ST_IXGOT: begin
          leg_idx[leg_sel] <= ix_rdata;
          if (ix_rdata > leg_bound[leg_sel]) begin
            if (hard_q) begin
              oob_err <= 1'b1;
              err_pos <= 13'(pos);
              st      <= ST_FIN;
            end else begin
              st <= ST_NEXT;
            end
          end else if (!leg_sel && leg_ix[1]) begin
            leg_sel <= 1'b1;
            st      <= ST_IXRD;
          end else begin
            st <= ST_SRD;
          end
        end
        ST_SRD: begin
          mem_req  <= 1'b1;
          mem_addr <= leg_ea[0];
          ret_st   <= ST_SGOT;
          st       <= ST_WAIT;
        end
        ST_SGOT: begin
          sdat <= mem_rdata;
          st   <= acc_q ? ST_DRD : ST_WR;
        end
        ST_DRD: begin
          mem_req  <= 1'b1;
          mem_addr <= leg_ea[1];
          ret_st   <= ST_DGOT;
          st       <= ST_WAIT;
        end
        ST_DGOT: begin
          ddat <= mem_rdata;
          st   <= ST_WR;
        end
        ST_WR: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= leg_ea[1];
          mem_wdata <= acc_q ? (sdat + ddat) : sdat;
          ret_st    <= ST_NEXT;
          st        <= ST_WAIT;
        end
        ST_NEXT: begin
          if (pos == cnt_q - 1'b1) begin
            st <= ST_FIN;
          end else begin
            pos     <= pos + 1'b1;
            leg_sel <= (mode_q == MODE_SCATTER);
            st      <= ST_IXRD;
          end
        end
        ST_FIN: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    rejected |-> (!mem_req && !ix_req)); // R4
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    oob_err |-> !mem_we); // R7
  AST_ERR_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    oob_err |-> (err_pos < 13'(cnt_q))); // R7
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && ix_req)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !ix_req)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R13
endmodule

// File: tb/idx_xfer_engine_test.sv
module idx_xfer_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  cfg_flags;
  logic [2:0]  cfg_op;
  logic [7:0]  cfg_chan;
  logic [15:0] cfg_rsvd;
  logic [15:0] cfg_count;
  logic [31:0] src_base, src_step, dst_base, dst_step, src_bound, dst_bound;
  logic [15:0] src_ix_base, dst_ix_base;
  logic        ix_req;
  logic [15:0] ix_addr;
  logic [31:0] ix_rdata = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        busy, done, rejected, oob_err;
  logic [12:0] err_pos;

  logic [31:0] dmem [0:4095];
  logic [31:0] imem [0:8191];
  int traffic = 0;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  idx_xfer_engine uut (
    .clk(clk), .rst(rst), .start(start), .cfg_flags(cfg_flags), .cfg_op(cfg_op),
    .cfg_chan(cfg_chan), .cfg_rsvd(cfg_rsvd), .cfg_count(cfg_count),
    .src_base(src_base), .src_step(src_step), .dst_base(dst_base), .dst_step(dst_step),
    .src_bound(src_bound), .dst_bound(dst_bound), .src_ix_base(src_ix_base),
    .dst_ix_base(dst_ix_base), .ix_req(ix_req), .ix_addr(ix_addr), .ix_rdata(ix_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .rejected(rejected),
    .oob_err(oob_err), .err_pos(err_pos)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) dmem[mem_addr[11:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= dmem[mem_addr[11:0]];
    if (ix_req) ix_rdata <= imem[ix_addr[12:0]];
    if (mem_req || ix_req) traffic <= traffic + 1;
  end

  function automatic logic [31:0] pat(input int a);
    return 32'(a) * 32'd7 + 32'd1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int a = 0; a < 4096; a++) dmem[a] = pat(a);
  endtask

  task automatic cfg_default();
    cfg_flags = 8'h00; cfg_op = 3'd0; cfg_chan = 8'd128; cfg_rsvd = 16'h0;
    cfg_count = 16'd0; src_base = 0; src_step = 1; dst_base = 0; dst_step = 1;
    src_bound = 32'hFFFF_FFFF; dst_bound = 32'hFFFF_FFFF;
    src_ix_base = 0; dst_ix_base = 0;
  endtask

  task automatic run(input string tag);
    int n;
    @(negedge clk);
    traffic = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL %s watchdog act=%0d exp=done", tag, n);
    end
  endtask

  task automatic t_reset();
    chk("R11 busy", 32'(busy), 0);
    chk("R11 done", 32'(done), 0);
    chk("R11 rejected", 32'(rejected), 0);
    chk("R11 oob_err", 32'(oob_err), 0);
    chk("R11 req", 32'({mem_req, mem_we, ix_req}), 0);
  endtask

  task automatic t_gather();
    int ix [4] = '{5, 2, 9, 2};
    init_mem(); cfg_default();
    for (int i = 0; i < 4; i++) imem[i] = 32'(ix[i]);
    cfg_count = 4; src_base = 100; src_step = 3; dst_base = 1000;
    run("R1");
    for (int i = 0; i < 4; i++) chk("R1 gather word", dmem[1000 + i], pat(100 + 3 * ix[i]));
    chk("R1 traffic", 32'(traffic), 12);
    chk("R13 done pulse", 32'(done), 1);
    @(negedge clk);
    chk("R13 done drops", 32'(done), 0);
  endtask

  task automatic t_scatter();
    int ix [4] = '{3, 0, 7, 1};
    init_mem(); cfg_default();
    for (int i = 0; i < 4; i++) imem[64 + i] = 32'(ix[i]);
    cfg_flags = 8'h01; cfg_count = 4; dst_ix_base = 64;
    src_base = 200; src_step = 2; dst_base = 2000; dst_step = 4;
    run("R2");
    for (int i = 0; i < 4; i++) chk("R2 scatter word", dmem[2000 + 4 * ix[i]], pat(200 + 2 * i));
    chk("R2 untouched", dmem[2008], pat(2008));
  endtask

  task automatic t_both();
    int sx [3] = '{1, 4, 6};
    int dx [3] = '{10, 0, 3};
    init_mem(); cfg_default();
    for (int i = 0; i < 3; i++) begin
      imem[128 + i] = 32'(sx[i]);
      imem[160 + i] = 32'(dx[i]);
    end
    cfg_flags = 8'h02; cfg_count = 3; src_ix_base = 128; dst_ix_base = 160;
    src_base = 300; src_step = 5; dst_base = 3000; dst_step = 2;
    run("R3");
    for (int i = 0; i < 3; i++) chk("R3 both word", dmem[3000 + 2 * dx[i]], pat(300 + 5 * sx[i]));
  endtask

  task automatic t_order();
    init_mem(); cfg_default();
    imem[192] = 8; imem[193] = 8;
    cfg_flags = 8'h01; cfg_count = 2; dst_ix_base = 192; src_base = 400; dst_base = 3500;
    run("R10");
    chk("R10 last duplicate wins", dmem[3508], pat(401));
  endtask

  task automatic t_accum();
    init_mem(); cfg_default();
    for (int i = 0; i < 3; i++) imem[200 + i] = 6;
    cfg_flags = 8'h09; cfg_op = 3'd1; cfg_count = 3; dst_ix_base = 200;
    src_base = 500; dst_base = 3600;
    run("R9");
    chk("R9 accumulate", dmem[3606], pat(3606) + pat(500) + pat(501) + pat(502));
    init_mem();
    cfg_flags = 8'h01;
    run("R9");
    chk("R9 add without dup flag copies", dmem[3606], pat(502));
  endtask

  task automatic t_bound_equal();
    init_mem(); cfg_default();
    imem[210] = 20;
    cfg_count = 1; src_ix_base = 210; src_bound = 20; dst_base = 3700;
    run("R6");
    chk("R6 equal bound moved", dmem[3700], pat(20));
    chk("R6 no error", 32'(oob_err), 0);
  endtask

  task automatic t_hard();
    init_mem(); cfg_default();
    imem[220] = 1; imem[221] = 50; imem[222] = 2;
    cfg_flags = 8'h04; cfg_count = 3; src_ix_base = 220; src_bound = 10;
    src_base = 600; dst_base = 3800;
    run("R7");
    chk("R7 oob_err", 32'(oob_err), 1);
    chk("R7 err_pos", 32'(err_pos), 1);
    chk("R7 earlier kept", dmem[3800], pat(601));
    chk("R7 failing not written", dmem[3801], pat(3801));
    chk("R7 later not written", dmem[3802], pat(3802));
  endtask

  task automatic t_soft();
    init_mem(); cfg_default();
    imem[220] = 1; imem[221] = 11; imem[222] = 2;
    cfg_count = 3; src_ix_base = 220; src_bound = 10; src_base = 600; dst_base = 3800;
    run("R8");
    chk("R8 oob_err stays 0", 32'(oob_err), 0);
    chk("R8 skipped word", dmem[3801], pat(3801));
    chk("R8 later moved", dmem[3802], pat(602));
    init_mem(); cfg_default();
    imem[230] = 30; imem[231] = 2;
    cfg_flags = 8'h01; cfg_count = 2; dst_ix_base = 230; dst_bound = 5;
    src_base = 700; dst_base = 3900;
    run("R8");
    chk("R8 dst leg skipped", dmem[3930], pat(3930));
    chk("R8 dst leg later moved", dmem[3902], pat(701));
  endtask

  task automatic t_reject();
    logic [7:0] bad_flags [4] = '{8'h03, 8'h10, 8'h41, 8'h80};
    for (int k = 0; k < 4; k++) begin
      cfg_default(); cfg_flags = bad_flags[k]; cfg_count = 2;
      run("R4");
      chk("R4 bad flags rejected", 32'(rejected), 1);
      chk("R4 bad flags no traffic", 32'(traffic), 0);
    end
    cfg_default(); cfg_rsvd = 16'h0001; cfg_count = 2;
    run("R4");
    chk("R4 reserved rejected", 32'(rejected), 1);
    cfg_default(); cfg_chan = 8'd127; cfg_count = 2;
    run("R4");
    chk("R4 channels rejected", 32'(rejected), 1);
    chk("R4 channels no traffic", 32'(traffic), 0);
  endtask

  task automatic t_count();
    init_mem(); cfg_default();
    cfg_count = 16'd4097;
    run("R5");
    chk("R5 4097 rejected", 32'(rejected), 1);
    chk("R5 4097 no traffic", 32'(traffic), 0);
    cfg_count = 16'd4096; src_base = 50; src_step = 0; dst_step = 0;
    run("R5");
    chk("R5 4096 accepted", 32'(rejected), 0);
    chk("R5 4096 traffic", 32'(traffic), 3 * 4096);
    chk("R5 4096 word", dmem[0], pat(50));
  endtask

  task automatic t_zero();
    cfg_default();
    run("R12");
    chk("R12 zero not rejected", 32'(rejected), 0);
    chk("R12 zero no traffic", 32'(traffic), 0);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) imem[i] = 0;
    init_mem(); cfg_default();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gather();
    t_scatter();
    t_both();
    t_order();
    t_accum();
    t_bound_equal();
    t_hard();
    t_soft();
    t_reject();
    t_count();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule